// File: doc/BRIEF.md
# Pseudo-Random Bit Source with Even/Odd Lane Splitter

This block produces a serial pseudo-random bit stream from a four-stage linear feedback shift register and divides that stream into two half-rate lanes. Bits at even positions of the stream (0, 2, 4, ...) go to one lane and bits at odd positions (1, 3, 5, ...) go to the other. Together the two lanes supply the in-phase and quadrature bits of one QPSK symbol.

A single toggle flop tracks the position within the stream. It acts as a clock enable that picks which of two capture registers takes the current serial bit. Every register runs on the one main clock. The clock is never gated or divided. An enable input freezes the whole block. A strobe marks each lane load, and a third strobe marks the moment a complete even/odd pair is ready.

Top module: `prbs_iq_splitter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the shift register is loaded with all ones, so `prbs_bit` reads 1. The same edge clears `phase`, `even_bit` and `odd_bit` to 0 and drives all three strobes low.
- R2: The shift register has four stages. `prbs_bit` is the last stage. Each enabled cycle moves every bit one stage on and writes the XOR of the third and fourth stages into the first stage. The serial stream b[n] (the value of `prbs_bit` before the n-th enabled edge since reset) therefore satisfies b[n+4] = b[n+1] XOR b[n], with b[0..3] = 1.
- R3: The serial stream repeats every 15 enabled cycles and has no shorter period. Across one period, every non-zero four-bit register state occurs exactly once, and the all-zero state never occurs.
- R4: `phase` inverts on every enabled cycle. It reads 0 when the next enabled edge belongs to the even lane and 1 when it belongs to the odd lane.
- R5: On an enabled edge with `phase` = 0, `even_bit` takes the current `prbs_bit`. `even_bit` therefore carries b[0], b[2], b[4], ... in turn.
- R6: On an enabled edge with `phase` = 1, `odd_bit` takes the current `prbs_bit`. `odd_bit` therefore carries b[1], b[3], b[5], ... in turn.
- R7: `even_vld` and `odd_vld` are each high for exactly the one cycle that follows a load of their own lane. They are never high together.
- R8: `pair_vld` is high for one cycle after each odd-lane load. While it is high, `even_bit` and `odd_bit` hold b[2k] and b[2k+1] of the same symbol.
- R9: While `en` is low, the shift register, `phase`, `even_bit` and `odd_bit` all hold their values, and the next cycle shows all three strobes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock; all registers use its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; when low the block holds its state |
| prbs_bit | output | 1 | Serial pseudo-random bit (last shift stage) |
| even_bit | output | 1 | Most recent even-position bit (I lane) |
| odd_bit | output | 1 | Most recent odd-position bit (Q lane) |
| phase | output | 1 | Lane selector: 0 = even lane next, 1 = odd lane next |
| even_vld | output | 1 | One-cycle pulse after an even-lane load |
| odd_vld | output | 1 | One-cycle pulse after an odd-lane load |
| pair_vld | output | 1 | One-cycle pulse when a full even/odd pair is available |

## Verification
The bench rebuilds the stream from the four-term recurrence and steps through a full period and more. A wrong tap would break the recurrence, and a stuck or wrong seed would give a period other than 15 or a repeated state. Lane assignment is checked bit by bit against alternate stream positions. A swapped selector, or a phase that starts at 1, would put b[1] on the even lane. Irregular enable patterns, including long idle runs, expose a design that lets the phase, the shift register or a strobe move while the enable is low. A reset in the middle of a run checks that the phase and the seed return together.

// File: rtl/prbs_split_pkg.sv
package prbs_split_pkg;
  localparam int LFSR_STAGES = 4;
  localparam int LFSR_TAP    = 3;
  localparam int SEED_ONES   = (1 << LFSR_STAGES) - 1;

  typedef logic [LFSR_STAGES-1:0] lfsr_t;

  // bit 0 is the first stage, bit LFSR_STAGES-1 the serial output
  function automatic logic lfsr_feedback(lfsr_t s);
    return s[LFSR_TAP-1] ^ s[LFSR_STAGES-1];
  endfunction

  function automatic lfsr_t lfsr_advance(lfsr_t s);
    return {s[LFSR_STAGES-2:0], lfsr_feedback(s)};
  endfunction
endpackage

// File: rtl/prbs_lfsr.sv
module prbs_lfsr
  import prbs_split_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  output lfsr_t state,
  output logic  serial
);
  lfsr_t state_q;

  always_ff @(posedge clk) begin
    if (rst)     state_q <= lfsr_t'(SEED_ONES);
    else if (en) state_q <= lfsr_advance(state_q);
  end

  assign state  = state_q;
  assign serial = state_q[LFSR_STAGES-1];
endmodule

// File: rtl/phase_toggle.sv
module phase_toggle (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic phase
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst)     phase_q <= 1'b0;
    else if (en) phase_q <= ~phase_q;
  end

  assign phase = phase_q;
endmodule

// File: rtl/lane_capture.sv
module lane_capture #(
  parameter logic LANE_PHASE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic phase,
  input  logic bit_in,
  output logic load,
  output logic bit_q,
  output logic loaded
);
  logic bit_r;
  logic loaded_r;

  assign load = en & (phase == LANE_PHASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_r    <= 1'b0;
      loaded_r <= 1'b0;
    end else begin
      loaded_r <= load;
      if (load) bit_r <= bit_in;
    end
  end

  assign bit_q  = bit_r;
  assign loaded = loaded_r;
endmodule

// File: rtl/prbs_iq_splitter.sv
module prbs_iq_splitter
  import prbs_split_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic prbs_bit,
  output logic even_bit,
  output logic odd_bit,
  output logic phase,
  output logic even_vld,
  output logic odd_vld,
  output logic pair_vld
);
  lfsr_t lfsr_state;
  logic  serial;
  logic  lane_sel;
  logic  even_load;
  logic  odd_load;
  logic  pair_q;

  prbs_lfsr u_lfsr (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .state  (lfsr_state),
    .serial (serial)
  );

  phase_toggle u_phase (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .phase (lane_sel)
  );

  lane_capture #(.LANE_PHASE(1'b0)) u_even (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .phase  (lane_sel),
    .bit_in (serial),
    .load   (even_load),
    .bit_q  (even_bit),
    .loaded (even_vld)
  );

  lane_capture #(.LANE_PHASE(1'b1)) u_odd (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .phase  (lane_sel),
    .bit_in (serial),
    .load   (odd_load),
    .bit_q  (odd_bit),
    .loaded (odd_vld)
  );

  // pair completes once the odd lane has taken its bit
  always_ff @(posedge clk) begin
    if (rst) pair_q <= 1'b0;
    else     pair_q <= odd_load;
  end

  assign prbs_bit = serial;
  assign phase    = lane_sel;
  assign pair_vld = pair_q;
endmodule

// File: rtl/prbs_iq_splitter_chk.sv
module prbs_iq_splitter_chk
  import prbs_split_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  en,
  input logic  prbs_bit,
  input logic  even_bit,
  input logic  odd_bit,
  input logic  phase,
  input logic  even_vld,
  input logic  odd_vld,
  input logic  pair_vld,
  input lfsr_t lfsr_state
);
  // R2
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> lfsr_state[LFSR_STAGES-1:1] == $past(lfsr_state[LFSR_STAGES-2:0]));

  // R3
  never_zero_chk: assert property (@(posedge clk) disable iff (rst)
    lfsr_state != '0);

  // R4
  phase_flip_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> phase != $past(phase));

  // R6
  odd_take_chk: assert property (@(posedge clk) disable iff (rst)
    odd_vld |-> odd_bit == $past(prbs_bit));

  // R5
  even_take_chk: assert property (@(posedge clk) disable iff (rst)
    even_vld |-> even_bit == $past(prbs_bit));

  // R7
  lane_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({even_vld, odd_vld}));

  // R8
  pair_after_odd_chk: assert property (@(posedge clk) disable iff (rst)
    pair_vld |-> odd_vld && $past(phase));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(lfsr_state) && $stable(phase) && $stable(even_bit)
            && $stable(odd_bit) && !even_vld && !odd_vld && !pair_vld);
endmodule

bind prbs_iq_splitter prbs_iq_splitter_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .prbs_bit   (prbs_bit),
  .even_bit   (even_bit),
  .odd_bit    (odd_bit),
  .phase      (phase),
  .even_vld   (even_vld),
  .odd_vld    (odd_vld),
  .pair_vld   (pair_vld),
  .lfsr_state (lfsr_state)
);

// File: tb/prbs_iq_splitter_test.sv
module prbs_iq_splitter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NBITS      = 320;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic prbs_bit, even_bit, odd_bit, phase, even_vld, odd_vld, pair_vld;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic stream [NBITS];
  logic obs    [NBITS];
  int   pos;
  logic x_even, x_odd, x_ev, x_ov, x_pv;

  always #(CLK_PERIOD/2) clk = ~clk;

  prbs_iq_splitter uut (
    .clk(clk), .rst(rst), .en(en), .prbs_bit(prbs_bit), .even_bit(even_bit),
    .odd_bit(odd_bit), .phase(phase), .even_vld(even_vld), .odd_vld(odd_vld),
    .pair_vld(pair_vld)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (stream pos %0d)", req, got, exp, pos);
    end
  endtask

  task automatic check_all();
    chk("R2 prbs_bit", int'(prbs_bit), int'(stream[pos]));
    chk("R4 phase", int'(phase), pos % 2);
    chk("R5 even_bit", int'(even_bit), int'(x_even));
    chk("R6 odd_bit", int'(odd_bit), int'(x_odd));
    chk("R7 even_vld", int'(even_vld), int'(x_ev));
    chk("R7 odd_vld", int'(odd_vld), int'(x_ov));
    chk("R8 pair_vld", int'(pair_vld), int'(x_pv));
  endtask

  // one clock with en = e, then check just after the edge
  task automatic tick(input logic e);
    en = e;
    @(posedge clk);
    #1;
    x_ev = 1'b0; x_ov = 1'b0; x_pv = 1'b0;
    if (e) begin
      if (pos % 2 == 0) begin x_even = stream[pos]; x_ev = 1'b1; end
      else begin x_odd = stream[pos]; x_ov = 1'b1; x_pv = 1'b1; end
      pos++;
    end
    check_all();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    en  = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
    pos = 0;
    x_even = 1'b0; x_odd = 1'b0; x_ev = 1'b0; x_ov = 1'b0; x_pv = 1'b0;
    // R1 reset state
    chk("R1 prbs_bit", int'(prbs_bit), 1);
    chk("R1 phase", int'(phase), 0);
    chk("R1 even_bit", int'(even_bit), 0);
    chk("R1 odd_bit", int'(odd_bit), 0);
    chk("R1 strobes", int'({even_vld, odd_vld, pair_vld}), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) stream[i] = 1'b1;
    for (int i = 0; i + 4 < NBITS; i++) stream[i+4] = stream[i+1] ^ stream[i];

    repeat (2) @(posedge clk);
    #1;
    do_reset();

    // R2 R5 R6 continuous run, recording the serial stream
    for (int k = 0; k < 60; k++) begin
      obs[pos] = prbs_bit;
      tick(1'b1);
    end

    // R3 period and state coverage from observed bits
    begin
      bit seen [16];
      int distinct = 0;
      for (int s = 0; s < 16; s++) seen[s] = 1'b0;
      for (int t = 0; t < 15; t++) begin
        int st;
        st = (int'(obs[t+3]) << 0) | (int'(obs[t+2]) << 1) |
             (int'(obs[t+1]) << 2) | (int'(obs[t]) << 3);
        if (!seen[st]) distinct++;
        seen[st] = 1'b1;
      end
      chk("R3 distinct states", distinct, 15);
      chk("R3 zero state absent", int'(seen[0]), 0);
      for (int t = 0; t + 15 < 60; t++)
        chk("R3 period 15", int'(obs[t+15]), int'(obs[t]));
      for (int p = 1; p < 15; p++) begin
        bit same = 1'b1;
        for (int t = 0; t < 30; t++) if (obs[t+p] != obs[t]) same = 1'b0;
        chk("R3 no shorter period", int'(same), 0);
      end
    end

    // R9 irregular enable pattern with idle runs
    for (int k = 0; k < 120; k++) begin
      logic e;
      e = ((k * 7 + 3) % 5 != 0) && !(k >= 50 && k < 58);
      tick(e);
    end

    // R1 mid-run reset, then R5 R6 R8 restart from b[0]
    tick(1'b1);
    do_reset();
    for (int k = 0; k < 20; k++) tick(1'b1);
    tick(1'b0);
    tick(1'b0);
    for (int k = 0; k < 10; k++) tick(k % 3 != 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule